// File: doc/BRIEF.md
# Multifactor Gain Compensation Pipeline

After a rotation stage whose coefficients may be zero, the accumulated gain on the x and y coordinates depends on the data. This block takes an (x, y) pair and a gain index that encodes which gain applies to it. It then scales both coordinates by a product of factors of the form (1 ± 2^-j). The factors are chosen so that the product cancels the gain.

For every possible gain, a parameter table holds a word that programs a chain of N_STAGE scaling stages. For each stage the word gives an enable, an add/subtract choice and a shift amount. A stage that is not enabled passes its value through unchanged. The table is read once when a sample enters. The word then moves down the pipeline with the sample, so each register stage can hold a different sample with a different gain, and the block accepts one sample per clock.

Each stage builds its shifted operand with a wired-shift network. This is one row of 2:1 multiplexers per shift bit, with the arithmetic shift in each row a power of two. One adder/subtractor follows the network. The block is meant to sit between a rotation core and its consumer. Working out the table contents is outside this block.

Top module: `scale_comp_pipe`

## Requirements
- R1: While rst_ni is low, valid_o, x_o and y_o are all zero.
- R2: valid_o equals the valid_i of N_STAGE+1 clocks earlier (8 with the defaults), and a sample's results appear in that same cycle.
- R3: A stage whose enable bit is 0 leaves its value unchanged. A table word of all zeros therefore returns x_i and y_i exactly.
- R4: An enabled stage with its subtract bit at 0 computes v + (v >>> j). Here >>> is an arithmetic right shift of the DATA_W-bit two's-complement value, so it rounds toward minus infinity.
- R5: An enabled stage with its subtract bit at 1 computes v - (v >>> j). With j = 0 this gives zero.
- R6: x and y pass through the same sequence of stage operations. Equal inputs give equal outputs.
- R7: The table word is chosen by the gain_idx_i of the entry cycle and stays with that sample. Back-to-back samples with different indices are each scaled by their own word.
- R8: Stages are applied in order from 0 to N_STAGE-1, each truncating its own result. The field for stage s sits at word bits [s*F +: F], where F = clog2(DATA_W)+2. Within a field, bit F-1 is the enable, bit F-2 is subtract, and bits F-3..0 give j.
- R9: Every add and subtract wraps modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample qualifier |
| gain_idx_i | input | clog2(N_GAIN) | Index of the gain to compensate |
| x_i | input | DATA_W | x coordinate, two's complement |
| y_i | input | DATA_W | y coordinate, two's complement |
| valid_o | output | 1 | Output sample qualifier |
| x_o | output | DATA_W | Compensated x |
| y_o | output | DATA_W | Compensated y |

## Verification
A new gain lookup at the entry register can fall in the same cycle as the scaling of older samples with other words further down the pipe. The bench provokes this by streaming samples on consecutive clocks, with indices that change every cycle, and with gaps in valid. Each output is judged bit-exactly against a shift-and-add model that is fed the word of that sample's own index. Hand-computed values pin down the corners: zeroing, doubling with wrap-around, and stage order.

// File: rtl/scale_comp_pkg.sv
package scale_comp_pkg;
  function automatic int shift_w(int data_w);
    return (data_w < 2) ? 1 : $clog2(data_w);
  endfunction

  // enable + subtract + shift amount
  function automatic int field_w(int data_w);
    return shift_w(data_w) + 2;
  endfunction

  function automatic int idx_w(int n_gain);
    return (n_gain < 2) ? 1 : $clog2(n_gain);
  endfunction
endpackage

// File: rtl/scale_ctrl_rom.sv
module scale_ctrl_rom
  import scale_comp_pkg::*;
#(
  parameter int N_GAIN = 16,
  parameter int WORD_W = 42,
  parameter logic [N_GAIN-1:0][WORD_W-1:0] TABLE = '0
) (
  input  logic [idx_w(N_GAIN)-1:0] idx_i,
  output logic [WORD_W-1:0]        word_o
);
  localparam int IDX_W = idx_w(N_GAIN);

  generate
    if (N_GAIN == (1 << IDX_W)) begin : g_full
      assign word_o = TABLE[idx_i];
    end else begin : g_part
      // unused codes map to an all-disabled word
      always_comb begin
        word_o = '0;
        for (int g = 0; g < N_GAIN; g++)
          if (idx_i == IDX_W'(g)) word_o = TABLE[g];
      end
    end
  endgenerate
endmodule

// File: rtl/scale_stage.sv
module scale_stage
  import scale_comp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]          v_i,
  input  logic [field_w(DATA_W)-1:0] fld_i,
  output logic [DATA_W-1:0]          v_o
);
  localparam int SH_W = shift_w(DATA_W);

  logic            en, sub;
  logic [SH_W-1:0] sh;
  assign en  = fld_i[SH_W+1];
  assign sub = fld_i[SH_W];
  assign sh  = fld_i[SH_W-1:0];

  // one mux row per shift bit, each a fixed wired shift of 2^b
  logic signed [DATA_W-1:0] row [SH_W+1];
  assign row[0] = $signed(v_i);

  generate
    for (genvar b = 0; b < SH_W; b++) begin : g_row
      localparam int AMT = 1 << b;
      assign row[b+1] = sh[b] ? (row[b] >>> AMT) : row[b];
    end
  endgenerate

  logic [DATA_W-1:0] term;
  assign term = en ? DATA_W'(row[SH_W]) : '0;
  assign v_o  = sub ? (v_i - term) : (v_i + term);
endmodule

// File: rtl/scale_comp_pipe.sv
module scale_comp_pipe
  import scale_comp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int N_GAIN  = 16,
  parameter int N_STAGE = 7,
  parameter logic [N_GAIN-1:0][N_STAGE*field_w(DATA_W)-1:0] CTRL_TABLE = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [idx_w(N_GAIN)-1:0]  gain_idx_i,
  input  logic [DATA_W-1:0]         x_i,
  input  logic [DATA_W-1:0]         y_i,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         x_o,
  output logic [DATA_W-1:0]         y_o
);
  localparam int FLD_W  = field_w(DATA_W);
  localparam int WORD_W = N_STAGE * FLD_W;

  logic [WORD_W-1:0] rom_word;

  scale_ctrl_rom #(
    .N_GAIN (N_GAIN),
    .WORD_W (WORD_W),
    .TABLE  (CTRL_TABLE)
  ) u_rom (
    .idx_i  (gain_idx_i),
    .word_o (rom_word)
  );

  logic [N_STAGE:0][DATA_W-1:0] x_q, y_q;
  logic [N_STAGE:0][WORD_W-1:0] ctrl_q;
  logic [N_STAGE:0]             vld_q;
  logic [N_STAGE-1:0][DATA_W-1:0] x_nxt, y_nxt;

  generate
    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
      scale_stage #(.DATA_W(DATA_W)) u_sx (
        .v_i   (x_q[s]),
        .fld_i (ctrl_q[s][s*FLD_W +: FLD_W]),
        .v_o   (x_nxt[s])
      );
      scale_stage #(.DATA_W(DATA_W)) u_sy (
        .v_i   (y_q[s]),
        .fld_i (ctrl_q[s][s*FLD_W +: FLD_W]),
        .v_o   (y_nxt[s])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      ctrl_q <= '0;
      vld_q  <= '0;
    end else begin
      x_q[0]    <= x_i;
      y_q[0]    <= y_i;
      ctrl_q[0] <= rom_word;
      vld_q[0]  <= valid_i;
      for (int s = 0; s < N_STAGE; s++) begin
        x_q[s+1]    <= x_nxt[s];
        y_q[s+1]    <= y_nxt[s];
        ctrl_q[s+1] <= ctrl_q[s];
        vld_q[s+1]  <= vld_q[s];
      end
    end
  end

  assign valid_o = vld_q[N_STAGE];
  assign x_o     = x_q[N_STAGE];
  assign y_o     = y_q[N_STAGE];
endmodule

// File: rtl/scale_comp_chk.sv
module scale_comp_chk #(
  parameter int DATA_W  = 16,
  parameter int N_STAGE = 7,
  parameter int FLD_W   = 6,
  parameter int WORD_W  = 42
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         valid_o,
  input logic [N_STAGE:0]             vld_q,
  input logic [N_STAGE:0][DATA_W-1:0] x_q,
  input logic [N_STAGE:0][DATA_W-1:0] y_q,
  input logic [N_STAGE:0][WORD_W-1:0] ctrl_q
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !valid_o); // R1

  generate
    for (genvar s = 0; s < N_STAGE; s++) begin : g_chk
      AST_VALID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q[s+1] == $past(vld_q[s])); // R2
      AST_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_q[s][s*FLD_W + FLD_W - 1] |=> (x_q[s+1] == $past(x_q[s])) && (y_q[s+1] == $past(y_q[s]))); // R3
      AST_XY_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_q[s] == y_q[s]) |=> (x_q[s+1] == y_q[s+1])); // R6
      AST_CTRL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_q[s+1] == $past(ctrl_q[s])); // R7
    end
  endgenerate
endmodule

bind scale_comp_pipe scale_comp_chk #(
  .DATA_W  (DATA_W),
  .N_STAGE (N_STAGE),
  .FLD_W   (FLD_W),
  .WORD_W  (WORD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .vld_q   (vld_q),
  .x_q     (x_q),
  .y_q     (y_q),
  .ctrl_q  (ctrl_q)
);

// File: tb/scale_comp_pipe_bench.sv
module scale_comp_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NG = 16;
  localparam int NS = 7;
  localparam int FW = 6;
  localparam int WW = NS * FW;
  localparam int LAT = NS + 1;

  function automatic logic [5:0] fld(logic en, logic sub, logic [3:0] sh);
    return {en, sub, sh};
  endfunction

  function automatic logic [NG-1:0][WW-1:0] mk_table();
    logic [NG-1:0][WW-1:0] t;
    t = '0;
    t[1][0*FW +: FW] = fld(1, 1, 2);
    t[2][0*FW +: FW] = fld(1, 0, 1);
    t[2][3*FW +: FW] = fld(1, 1, 3);
    t[2][6*FW +: FW] = fld(1, 1, 15);
    t[3][0*FW +: FW] = fld(1, 1, 1);
    t[3][1*FW +: FW] = fld(1, 0, 3);
    t[3][2*FW +: FW] = fld(1, 1, 5);
    t[3][3*FW +: FW] = fld(1, 0, 7);
    t[3][4*FW +: FW] = fld(1, 1, 9);
    t[3][5*FW +: FW] = fld(1, 0, 11);
    t[3][6*FW +: FW] = fld(1, 1, 13);
    t[5][0*FW +: FW] = fld(1, 1, 0);
    t[6][4*FW +: FW] = fld(1, 0, 1);
    t[7][0*FW +: FW] = fld(1, 0, 0);
    return t;
  endfunction

  localparam logic [NG-1:0][WW-1:0] TBL = mk_table();

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [3:0] gain_idx_i = '0;
  logic [DW-1:0] x_i = '0, y_i = '0;
  logic valid_o;
  logic [DW-1:0] x_o, y_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scale_comp_pipe #(
    .DATA_W (DW), .N_GAIN (NG), .N_STAGE (NS), .CTRL_TABLE (TBL)
  ) u_scale_comp_pipe (
    .clk_i, .rst_ni, .valid_i, .gain_idx_i, .x_i, .y_i, .valid_o, .x_o, .y_o
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] sx [64];
  logic [DW-1:0] sy [64];
  logic [3:0]    si [64];
  logic          sv [64];
  int            n_s;
  logic [31:0]   lcg = 32'h1234_5678;

  function automatic logic [DW-1:0] model(logic [DW-1:0] v, logic [WW-1:0] w);
    logic signed [DW-1:0] a, t;
    logic [5:0] f;
    a = $signed(v);
    for (int s = 0; s < NS; s++) begin
      f = w[s*FW +: FW];
      if (f[5]) begin
        t = a >>> f[3:0];
        a = f[4] ? a - t : a + t;
      end
    end
    return a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  task automatic add_s(logic v, logic [3:0] idx, logic [DW-1:0] x, logic [DW-1:0] y);
    sv[n_s] = v; si[n_s] = idx; sx[n_s] = x; sy[n_s] = y;
    n_s++;
  endtask

  // drives the queued samples back to back, checks every output slot
  task automatic run_stream(string req);
    for (int c = 0; c < n_s + LAT; c++) begin
      @(negedge clk_i);
      if (c >= LAT) begin
        chk({req, " R2 valid"}, 32'(valid_o), 32'(sv[c-LAT]));
        if (sv[c-LAT]) begin
          chk({req, " x"}, 32'(x_o), 32'(model(sx[c-LAT], TBL[si[c-LAT]])));
          chk({req, " y"}, 32'(y_o), 32'(model(sy[c-LAT], TBL[si[c-LAT]])));
        end
      end else begin
        chk({req, " R2 no early valid"}, 32'(valid_o), 32'd0);
      end
      if (c < n_s) begin
        valid_i = sv[c]; gain_idx_i = si[c]; x_i = sx[c]; y_i = sy[c];
      end else begin
        valid_i = 1'b0; x_i = '0; y_i = '0; gain_idx_i = '0;
      end
    end
    n_s = 0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    valid_i = 1'b1; x_i = 16'h1111; y_i = 16'h2222;
    @(negedge clk_i);
    chk("R1 valid_o in reset", 32'(valid_o), 32'd0);
    chk("R1 x_o in reset", 32'(x_o), 32'd0);
    chk("R1 y_o in reset", 32'(y_o), 32'd0);
    valid_i = 1'b0; x_i = '0; y_i = '0;
    rst_ni = 1'b1;
    for (int k = 0; k < LAT; k++) @(negedge clk_i);
    chk("R1 valid_o after reset", 32'(valid_o), 32'd0);
  endtask

  task automatic t_identity();
    add_s(1, 0, 16'h8000, 16'h7fff);
    add_s(1, 0, 16'hffff, 16'h0001);
    add_s(1, 9, 16'h1234, 16'hedcb);
    run_stream("R3 identity");
  endtask

  task automatic t_hand();
    add_s(1, 1, 16'd100, 16'hff9c);     // 100-25=75, -100+25=-75
    add_s(1, 6, 16'd7, 16'hfff9);       // 7+3=10, -7+(-4)=-11
    add_s(1, 5, 16'h4321, 16'h8001);    // v-v = 0
    add_s(1, 7, 16'h5000, 16'h3000);    // doubling wraps to 0xa000
    run_stream("R4 R5 R9 model");
    add_s(1, 1, 16'd100, 16'hff9c);
    add_s(1, 6, 16'd7, 16'hfff9);
    add_s(1, 5, 16'h4321, 16'h8001);
    add_s(1, 7, 16'h5000, 16'h3000);
    for (int c = 0; c < n_s + LAT; c++) begin
      @(negedge clk_i);
      if (c == LAT)     begin chk("R5 sub x", 32'(x_o), 32'd75);   chk("R5 sub y", 32'(y_o), 32'hffb5); end
      if (c == LAT + 1) begin chk("R4 add x", 32'(x_o), 32'd10);   chk("R4 add y", 32'(y_o), 32'hfff5); end
      if (c == LAT + 2) begin chk("R5 zero x", 32'(x_o), 32'd0);   chk("R5 zero y", 32'(y_o), 32'd0); end
      if (c == LAT + 3) begin chk("R9 wrap x", 32'(x_o), 32'ha000); chk("R9 y", 32'(y_o), 32'h6000); end
      if (c < n_s) begin
        valid_i = sv[c]; gain_idx_i = si[c]; x_i = sx[c]; y_i = sy[c];
      end else begin
        valid_i = 1'b0; x_i = '0; y_i = '0; gain_idx_i = '0;
      end
    end
    n_s = 0;
  endtask

  task automatic t_order();
    // idx 2: 1000 -> 1500 -> 1500-187=1313 -> 1313-0=1313
    add_s(1, 2, 16'd1000, 16'h7fff);
    add_s(1, 3, 16'h6abc, 16'h9001);
    add_s(1, 2, 16'h8000, 16'h0003);
    run_stream("R8 stage order");
    add_s(1, 2, 16'd1000, 16'd1000);
    for (int c = 0; c < n_s + LAT; c++) begin
      @(negedge clk_i);
      if (c == LAT) chk("R8 hand order", 32'(x_o), 32'd1313);
      if (c < n_s) begin
        valid_i = sv[c]; gain_idx_i = si[c]; x_i = sx[c]; y_i = sy[c];
      end else valid_i = 1'b0;
    end
    n_s = 0;
  endtask

  task automatic t_xy_same();
    logic [DW-1:0] v;
    for (int k = 0; k < 6; k++) begin
      v = rnd();
      add_s(1, 4'(k % 4), v, v);
    end
    run_stream("R6 same x y");
  endtask

  task automatic t_stream();
    logic [3:0] seq [7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7};
    for (int k = 0; k < 21; k++) add_s(1, seq[k % 7], rnd(), rnd());
    run_stream("R7 back to back");
  endtask

  task automatic t_gaps();
    add_s(1, 3, rnd(), rnd());
    add_s(0, 1, rnd(), rnd());
    add_s(1, 1, rnd(), rnd());
    add_s(1, 2, rnd(), rnd());
    add_s(0, 3, rnd(), rnd());
    add_s(0, 3, rnd(), rnd());
    add_s(1, 6, rnd(), rnd());
    run_stream("R2 valid gaps");
  endtask

  initial begin
    n_s = 0;
    t_reset();
    t_identity();
    t_hand();
    t_order();
    t_xy_same();
    t_stream();
    t_gaps();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule